// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Level Flags

This block is a single-clock first-in first-out buffer. It holds `DEPTH` words of `DATA_W` bits, 36 by default. A word is written when the active-low write enable is sampled low at a rising clock edge. A word is read when the active-low read enable is sampled low. The read data comes from a register and is updated at the same edge that accepts the read.

Five active-low level indicators report the fill state:
- empty
- full
- more than half full
- almost empty, below a programmable empty threshold
- almost full, above a programmable full threshold

All five are registered. Each one changes at the same edge that changes the stored word count. The two threshold values come from a separate offset register block and are plain inputs here.

The storage interface uses enables rather than valid/ready, and back-pressure is shown through the indicators:
- A write offered while the full indicator is low is dropped. The writer must hold off until that indicator goes high.
- A read offered while the empty indicator is low has no effect. The read data stays as it was.
- A write and a read offered in the same cycle are both accepted when neither indicator blocks them. The count does not change.

An active-low asynchronous master reset empties the buffer and returns every indicator to its empty-state value.

Top module: `fifo_lvl_flags`

## Requirements
- R1: While and after master reset (`rst_n` low), with no traffic: `empty_n`=0, `aempty_n`=0, `full_n`=1, `half_n`=1, `afull_n`=1, `rd_data`=0.
- R2: Words are read out in the order they were written. `rd_data` takes the oldest stored word at the rising edge that accepts a read, and holds its value at every other edge.
- R3: A read offered (`rd_en_n`=0) while `empty_n` is low is ignored. `rd_data` and the word count stay unchanged.
- R4: A write offered (`wr_en_n`=0) while `full_n` is low is ignored. The word is discarded and the count stays at `DEPTH`.
- R5: `empty_n` is registered and is low exactly when the buffer holds 0 words. It goes low at the edge of the read that removes the last word.
- R6: `full_n` is registered and is low exactly when the buffer holds `DEPTH` words. The first read from a full buffer raises it at that edge.
- R7: `half_n` is low exactly when the buffer holds more than `DEPTH/2` words.
- R8: `aempty_n` is low exactly when the buffer holds `empty_off` words or fewer.
- R9: `afull_n` is low exactly when the buffer holds `DEPTH - full_off` words or more.
- R10: A write and a read accepted at the same edge leave the word count unchanged.
- R11: Both offsets accept any value from 0 to `DEPTH-1`. A change of offset shows on the indicators at the next rising edge, even when there is no traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Word to write |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W | Registered read word |
| empty_off | input | $clog2(DEPTH) | Empty offset n for the almost-empty indicator |
| full_off | input | $clog2(DEPTH) | Full offset m for the almost-full indicator |
| empty_n | output | 1 | Empty indicator, active low |
| full_n | output | 1 | Full indicator, active low |
| half_n | output | 1 | More-than-half-full indicator, active low |
| aempty_n | output | 1 | Almost-empty indicator, active low |
| afull_n | output | 1 | Almost-full indicator, active low |

## Verification
The bench targets the following corner cases, each with the failure it exposes:
- A write pushed into a full buffer. A design that stores it would overwrite the oldest word and later return data out of order.
- A read from an empty buffer. A faulty design would let the count wrap, or would change `rd_data`.
- Reads and writes in the same cycle at the empty and full boundaries. A design that accepts both without checking the indicators would step the count the wrong way.
- Offsets of 0 and `DEPTH-1`, and offsets changed while the buffer is idle. These catch off-by-one errors in the threshold compares and indicators that only update on traffic.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  // Registered level indicators, all active low.
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
    logic aempty_n;
    logic afull_n;
  } lvl_flags_t;

  // Indicator values held by an empty buffer.
  localparam lvl_flags_t FLAGS_AT_RESET = '{
    empty_n:  1'b0,
    full_n:   1'b1,
    half_n:   1'b1,
    aempty_n: 1'b0,
    afull_n:  1'b1
  };

endpackage

// File: rtl/fifo_lvl_ptrs.sv
// Accepts or refuses the offered write and read from the registered
// indicators, keeps the pointers and the word count.
module fifo_lvl_ptrs #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic              full_n,
  input  logic              empty_n,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  level_nxt
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  assign wr_go = !wr_en_n && full_n;
  assign rd_go = !rd_en_n && empty_n;

  always_comb begin
    unique case ({wr_go, rd_go})
      2'b10:   level_nxt = level + 1'b1;
      2'b01:   level_nxt = level - 1'b1;
      default: level_nxt = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      level   <= '0;
    end else begin
      if (wr_go) wr_addr <= bump(wr_addr);
      if (rd_go) rd_addr <= bump(rd_addr);
      level <= level_nxt;
    end
  end

endmodule

// File: rtl/fifo_lvl_store.sv
// Word storage with a registered read port.
module fifo_lvl_store #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo_lvl_flag_gen.sv
// Computes every indicator from the next-cycle word count and registers
// it, so each indicator changes at the same edge as the count.
module fifo_lvl_flag_gen
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level_nxt,
  input  logic [OFF_W-1:0] empty_off,
  input  logic [OFF_W-1:0] full_off,
  output lvl_flags_t       flags
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] ae_lim;
  logic [CNT_W-1:0] af_lim;
  lvl_flags_t       flags_nxt;

  assign ae_lim = CNT_W'(empty_off);
  assign af_lim = FULL_CNT - CNT_W'(full_off);

  always_comb begin
    flags_nxt.empty_n  = (level_nxt != '0);
    flags_nxt.full_n   = (level_nxt != FULL_CNT);
    flags_nxt.half_n   = (level_nxt <= HALF_CNT);
    flags_nxt.aempty_n = (level_nxt > ae_lim);
    flags_nxt.afull_n  = (level_nxt < af_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_AT_RESET;
    else        flags <= flags_nxt;
  end

endmodule

// File: rtl/fifo_lvl_flags.sv
module fifo_lvl_flags
  import fifo_lvl_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  input  logic [OFF_W-1:0]  empty_off,
  input  logic [OFF_W-1:0]  full_off,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);

  logic              wr_go;
  logic              rd_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  level;
  logic [CNT_W-1:0]  level_nxt;
  lvl_flags_t        flags;

  fifo_lvl_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .full_n    (flags.full_n),
    .empty_n   (flags.empty_n),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .level     (level),
    .level_nxt (level_nxt)
  );

  fifo_lvl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  fifo_lvl_flag_gen #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_nxt (level_nxt),
    .empty_off (empty_off),
    .full_off  (full_off),
    .flags     (flags)
  );

  assign empty_n  = flags.empty_n;
  assign full_n   = flags.full_n;
  assign half_n   = flags.half_n;
  assign aempty_n = flags.aempty_n;
  assign afull_n  = flags.afull_n;

endmodule

// File: rtl/fifo_lvl_flags_chk.sv
module fifo_lvl_flags_chk #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty_n,
  input logic              full_n,
  input logic              half_n,
  input logic [CNT_W-1:0]  level
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && wr_en_n) |=> ($stable(rd_data) && !empty_n));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && rd_en_n) |=> (level == FULL_CNT && !full_n));

  assert_empty_tracks_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) == !empty_n);

  assert_full_tracks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_CNT) == !full_n);

  assert_half_tracks_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level > HALF_CNT) == !half_n);

  assert_level_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_CNT);

  assert_rw_keeps_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !rd_en_n && empty_n && full_n) |=> $stable(level));

endmodule

bind fifo_lvl_flags fifo_lvl_flags_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en_n (wr_en_n),
  .rd_en_n (rd_en_n),
  .rd_data (rd_data),
  .empty_n (empty_n),
  .full_n  (full_n),
  .half_n  (half_n),
  .level   (level)
);

// File: tb/fifo_lvl_flags_bench.sv
`timescale 1ns/100ps
module fifo_lvl_flags_bench;

  localparam int DW = 36;
  localparam int D  = 16;
  localparam int OW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_n = 1'b1;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [OW-1:0] empty_off = '0;
  logic [OW-1:0] full_off = '0;
  logic [DW-1:0] rd_data;
  logic          empty_n, full_n, half_n, aempty_n, afull_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] last_out = '0;

  always #2.5 clk = ~clk;

  fifo_lvl_flags #(.DATA_W(DW), .DEPTH(D)) u_fifo_lvl_flags (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .empty_off(empty_off),
    .full_off(full_off), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_flags();
    int c = q.size();
    chk("R5 empty_n", 64'(empty_n), 64'(c != 0));
    chk("R6 full_n", 64'(full_n), 64'(c != D));
    chk("R7 half_n", 64'(half_n), 64'(c <= D / 2));
    chk("R8 aempty_n", 64'(aempty_n), 64'(c > int'(empty_off)));
    chk("R9 afull_n", 64'(afull_n), 64'(c < D - int'(full_off)));
  endtask

  // Called at a falling edge: drives inputs, waits one rising edge, checks.
  task automatic step(input bit w, input bit r, input logic [DW-1:0] d);
    bit wacc, racc;
    wr_en_n = !w;
    rd_en_n = !r;
    wr_data = d;
    racc = r && (q.size() > 0);
    wacc = w && (q.size() < D);
    @(posedge clk);
    @(negedge clk);
    if (racc) last_out = q.pop_front();
    if (wacc) q.push_back(d);
    if (r && !racc) chk("R3 rd_data held on empty read", 64'(rd_data), 64'(last_out));
    else            chk("R2 rd_data order", 64'(rd_data), 64'(last_out));
    chk_flags();
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {4'($urandom), $urandom};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    empty_off = 3;
    full_off = 2;
    wr_en_n = 1'b0;
    rd_en_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state even with enables asserted
    chk("R1 empty_n", 64'(empty_n), 64'd0);
    chk("R1 aempty_n", 64'(aempty_n), 64'd0);
    chk("R1 full_n", 64'(full_n), 64'd1);
    chk("R1 half_n", 64'(half_n), 64'd1);
    chk("R1 afull_n", 64'(afull_n), 64'd1);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk_flags();

    // R3: read of empty buffer, then simultaneous read/write on empty
    step(0, 1, '0);
    step(1, 1, 36'h0_1234_5678);
    chk("R3 count after empty r+w", 64'(q.size()), 64'd1);

    // Fill to full, then push one more (R4)
    while (q.size() < D) step(1, 0, rnd_word());
    chk("R6 full_n low at D", 64'(full_n), 64'd0);
    step(1, 0, 36'hF_DEAD_BEEF);
    chk("R4 full_n still low after dropped write", 64'(full_n), 64'd0);
    // R10 at full: write blocked, read accepted -> count D-1
    step(1, 1, 36'h0_AAAA_5555);
    chk("R6 first read from full raises full_n", 64'(full_n), 64'd1);
    step(1, 1, 36'h0_5555_AAAA);
    chk("R10 count unchanged on r+w", 64'(q.size()), 64'(D - 1));
    // Drain; R4: exactly D-1 words remain, the dropped word never appears
    for (int i = 0; i < D - 2; i++) step(0, 1, '0);
    chk("R4 one word left", 64'(empty_n), 64'd1);
    step(0, 1, '0);
    chk("R5 empty_n low after last word", 64'(empty_n), 64'd0);
    step(0, 1, '0);

    // R11: offsets at extremes, changed with no traffic
    for (int i = 0; i < 5; i++) step(1, 0, rnd_word());
    empty_off = OW'(D - 1);
    full_off = '0;
    step(0, 0, '0);
    chk("R11 aempty_n with n=D-1", 64'(aempty_n), 64'd0);
    chk("R11 afull_n with m=0", 64'(afull_n), 64'd1);
    empty_off = '0;
    full_off = OW'(D - 1);
    step(0, 0, '0);
    chk("R11 aempty_n with n=0", 64'(aempty_n), 64'd1);
    chk("R11 afull_n with m=D-1", 64'(afull_n), 64'd0);

    // Constrained random traffic in biased phases
    for (int ph = 0; ph < 12; ph++) begin
      int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
      empty_off = OW'($urandom_range(D - 1, 0));
      full_off = OW'($urandom_range(D - 1, 0));
      for (int i = 0; i < 300; i++) begin
        bit w = ($urandom_range(99, 0) < wp);
        bit r = ($urandom_range(99, 0) < (100 - wp));
        step(w, r, rnd_word());
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule